// File: doc/BRIEF.md
# Vectored Interrupt Controller with Packet-Sized Vector Slots

This block gathers the interrupt sources of a processor core and selects one of them for service. The sources are a reset request, a non-maskable request and twelve maskable lines numbered 4 to 15. Numbers 2 and 3 are held back and are never serviced. Every source is edge-detected and held as pending. When the core signals that it is ready, the lowest-numbered eligible pending source is taken.

A take produces a one-cycle acknowledge. It also presents the source number on a 4-bit output and the address of that source's vector slot. Each slot is one eight-instruction fetch packet of 32 bytes. The slot address is therefore the relocatable table base plus the number times 0x20. The fetch unit branches to that address.

The pending bit of the taken source clears on the edge that raises the acknowledge. One edge therefore leads to exactly one service.

Top module: `vec_irq_ctrl`

## Requirements
- R1: During reset and after it, until the first take, `iack_o` is 0, `inum_o` is 0 and `vec_addr_o` is 0.
- R2: When `iack_o` is high, `vec_addr_o` equals `tbl_base_i` plus `inum_o` times 0x20. The base is the value sampled in the cycle before the acknowledge. `vec_addr_o` holds that value until the next take.
- R3: Source numbers on `inum_o` are as follows. The reset request is 0 and the non-maskable request is 1. Maskable line k is k, for k from 4 to 15, and drives bit k-4 of `irq_i`. Numbers 2 and 3 never appear with `iack_o`. `inum_o` holds its value between acknowledges.
- R4: The priority is fixed: when several eligible sources are pending, the lowest number is taken first.
- R5: Line k (k from 4 to 15) is eligible only while bit k-4 of `irq_en_i` is 1 and `gie_i` is 1. Reset and non-maskable requests are eligible regardless of `irq_en_i` and `gie_i`.
- R6: A low-to-high transition on a source input sets its pending bit. A level held high does not set it again. A pending bit that is not eligible stays set and is serviced once it becomes eligible.
- R7: A take happens only at a clock edge where `cpu_rdy_i` is 1 and `iack_o` is 0. `iack_o` is high in the cycle after that edge and lasts exactly one cycle.
- R8: The taken source's pending bit clears on the edge that raises `iack_o`. One edge gives exactly one acknowledge.
- R9: Further rising edges on a source that is already pending merge into the single pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_src_i | input | 1 | Reset interrupt request (number 0) |
| nmi_i | input | 1 | Non-maskable request (number 1) |
| irq_i | input | 12 | Maskable lines; bit k-4 is line k |
| irq_en_i | input | 12 | Per-line enable; bit k-4 enables line k |
| gie_i | input | 1 | Global enable for the maskable lines |
| tbl_base_i | input | 32 | Vector table base address |
| cpu_rdy_i | input | 1 | Core ready to accept an interrupt |
| vec_addr_o | output | 32 | Vector slot address of the taken source |
| iack_o | output | 1 | One-cycle acknowledge pulse |
| inum_o | output | 4 | Number of the taken source |

## Verification
Several properties are checked by assertions on every cycle:
- the acknowledge is a single-cycle pulse that follows a ready cycle;
- the slot address matches the base and number;
- reserved numbers are never produced;
- an edge always leaves its source pending;
- the selector never passes over a lower-numbered request;
- a taken maskable line was enabled at the time it was taken.

Other behaviours only show up across a sequence of events, so only the bench scenarios can show them:
- the order of service when several sources are pending together;
- that a held level or a second edge does not add a second service;
- that a masked request survives until it is enabled;
- that relocating the base moves the vectors.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_SLOTS          = 16;
  localparam int VIC_FIRST_MASKABLE = 4;
  localparam int VIC_ADDR_W         = 32;
  localparam int VIC_PACKET_INSNS   = 8;
  localparam int VIC_INSN_BYTES     = 4;
  localparam int VIC_PACKET_BYTES   = VIC_PACKET_INSNS * VIC_INSN_BYTES;
endpackage

// File: rtl/vic_pend_bank.sv
module vic_pend_bank #(
  parameter int SLOTS = vic_pkg::VIC_SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] src_i,
  input  logic [SLOTS-1:0] clr_i,
  output logic [SLOTS-1:0] pend_o
);
  logic [SLOTS-1:0] src_q;
  logic [SLOTS-1:0] pend_q;
  logic [SLOTS-1:0] pend_d;
  logic [SLOTS-1:0] rise;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    always_comb begin
      rise[k]   = src_i[k] & ~src_q[k];
      pend_d[k] = rise[k] | (pend_q[k] & ~clr_i[k]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[k]  <= 1'b0;
        pend_q[k] <= 1'b0;
      end else begin
        src_q[k]  <= src_i[k];
        pend_q[k] <= pend_d[k];
      end
    end

    AST_EDGE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i[k] && !src_q[k]) |=> pend_q[k]); // R6
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int SLOTS = vic_pkg::VIC_SLOTS,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic [SLOTS-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  always_comb begin
    if (any_o) begin
      AST_PICK_LOWEST: assert (req_i[idx_o] && ((req_i & ((SLOTS'(1) << idx_o) - SLOTS'(1))) == '0)); // R4
    end
  end
endmodule

// File: rtl/vic_vec_reg.sv
module vic_vec_reg #(
  parameter int ADDR_W = vic_pkg::VIC_ADDR_W,
  parameter int IDX_W  = 4,
  parameter int SHIFT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              iack_o,
  output logic [IDX_W-1:0]  inum_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic              iack_q, iack_d;
  logic [IDX_W-1:0]  inum_q, inum_d;
  logic [ADDR_W-1:0] vec_q, vec_d;
  logic [ADDR_W-1:0] slot_off;

  always_comb begin
    slot_off = ADDR_W'(idx_i) << SHIFT;
    iack_d   = take_i;
    inum_d   = inum_q;
    vec_d    = vec_q;
    if (take_i) begin
      inum_d = idx_i;
      vec_d  = base_i + slot_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iack_q <= 1'b0;
      inum_q <= '0;
      vec_q  <= '0;
    end else begin
      iack_q <= iack_d;
      inum_q <= inum_d;
      vec_q  <= vec_d;
    end
  end

  assign iack_o = iack_q;
  assign inum_o = inum_q;
  assign vec_o  = vec_q;

  AST_IACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |=> !iack_o); // R7
  AST_VEC_FROM_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (vec_o == $past(base_i) + (ADDR_W'(inum_o) << SHIFT))); // R2
  AST_INUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_o |-> ($stable(inum_o) && $stable(vec_o))); // R3
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int SLOTS        = vic_pkg::VIC_SLOTS,
  parameter int FIRST_MASK   = vic_pkg::VIC_FIRST_MASKABLE,
  parameter int ADDR_W       = vic_pkg::VIC_ADDR_W,
  parameter int PACKET_BYTES = vic_pkg::VIC_PACKET_BYTES,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int SHIFT = $clog2(PACKET_BYTES),
  localparam int NMASK = SLOTS - FIRST_MASK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_src_i,
  input  logic              nmi_i,
  input  logic [NMASK-1:0]  irq_i,
  input  logic [NMASK-1:0]  irq_en_i,
  input  logic              gie_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  input  logic              cpu_rdy_i,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              iack_o,
  output logic [IDX_W-1:0]  inum_o
);
  logic [SLOTS-1:0] src_all;
  logic [SLOTS-1:0] en_all;
  logic [SLOTS-1:0] pend;
  logic [SLOTS-1:0] elig;
  logic [SLOTS-1:0] clr;
  logic             any_elig;
  logic [IDX_W-1:0] pick;
  logic             take;

  // Slots between the non-maskable source and the first maskable line stay tied off.
  always_comb begin
    src_all                   = '0;
    en_all                    = '0;
    src_all[0]                = rst_src_i;
    src_all[1]                = nmi_i;
    en_all[1:0]               = 2'b11;
    src_all[SLOTS-1:FIRST_MASK] = irq_i;
    en_all[SLOTS-1:FIRST_MASK]  = irq_en_i & {NMASK{gie_i}};
  end

  vic_pend_bank #(.SLOTS(SLOTS)) pend_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_all),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign elig = pend & en_all;

  vic_prio_pick #(.SLOTS(SLOTS)) pick_i (
    .req_i (elig),
    .any_o (any_elig),
    .idx_o (pick)
  );

  always_comb begin
    take = cpu_rdy_i & any_elig & ~iack_o;
    clr  = '0;
    if (take) clr[pick] = 1'b1;
  end

  vic_vec_reg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT(SHIFT)) vec_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .idx_i  (pick),
    .base_i (tbl_base_i),
    .iack_o (iack_o),
    .inum_o (inum_o),
    .vec_o  (vec_addr_o)
  );

  AST_TAKE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> ($past(cpu_rdy_i) && !$past(iack_o))); // R7
  AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> (inum_o < IDX_W'(2) || inum_o >= IDX_W'(FIRST_MASK))); // R3
  AST_MASKED_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_o && inum_o >= IDX_W'(FIRST_MASK)) |->
      ($past(gie_i) && (|(($past(irq_en_i) >> (inum_o - IDX_W'(FIRST_MASK))) & NMASK'(1))))); // R5
endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 12;

  logic        clk;
  logic        rst_n;
  logic        rst_src, nmi, gie, rdy;
  logic [NM-1:0] irq, en;
  logic [31:0] base;
  logic [31:0] vec_addr;
  logic        iack;
  logic [3:0]  inum;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  int m_pend [16];
  int m_prev [16];
  int m_iack, m_inum;
  longint m_vec;

  int ack_q [$];
  longint vec_q [$];

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rst_src_i(rst_src), .nmi_i(nmi),
    .irq_i(irq), .irq_en_i(en), .gie_i(gie), .tbl_base_i(base),
    .cpu_rdy_i(rdy), .vec_addr_o(vec_addr), .iack_o(iack), .inum_o(inum)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int src_of(int k);
    if (k == 0) return int'(rst_src);
    if (k == 1) return int'(nmi);
    if (k < 4) return 0;
    return int'(irq[k-4]);
  endfunction

  function automatic int en_of(int k);
    if (k < 2) return 1;
    if (k < 4) return 0;
    return int'(gie && en[k-4]);
  endfunction

  // Behavioural reference: pending set, priority pick and acknowledge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) begin m_pend[k] = 0; m_prev[k] = 0; end
      m_iack = 0; m_inum = 0; m_vec = 0;
    end else begin
      int sel;
      int take;
      sel = -1;
      for (int k = 15; k >= 0; k--) if (m_pend[k] != 0 && en_of(k) != 0) sel = k;
      take = (rdy && sel >= 0 && m_iack == 0) ? 1 : 0;
      for (int k = 0; k < 16; k++) begin
        int rise;
        rise = (src_of(k) != 0 && m_prev[k] == 0) ? 1 : 0;
        if (take != 0 && sel == k) m_pend[k] = 0;
        if (rise != 0) m_pend[k] = 1;
        m_prev[k] = src_of(k);
      end
      m_iack = take;
      if (take != 0) begin
        m_inum = sel;
        m_vec  = (longint'(base) + longint'(sel) * 32) & 64'hFFFF_FFFF;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7", "iack", longint'(iack), longint'(m_iack));
      chk("R3", "inum", longint'(inum), longint'(m_inum));
      chk("R2", "vec",  longint'(vec_addr), m_vec);
      if (iack) begin ack_q.push_back(int'(inum)); vec_q.push_back(longint'(vec_addr)); end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_line(input int k);
    irq[k-4] = 1'b1; @(negedge clk); irq[k-4] = 1'b0;
  endtask

  task automatic clear_log();
    ack_q.delete(); vec_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; rst_src = 0; nmi = 0; gie = 1; rdy = 1;
    irq = '0; en = '1; base = 32'h0000_1000;
    idle(3);
    // R1: outputs quiet while in reset
    chk("R1", "iack in reset", longint'(iack), 0);
    chk("R1", "vec in reset", longint'(vec_addr), 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1", "inum after reset", longint'(inum), 0);
    chk("R1", "vec after reset", longint'(vec_addr), 0);

    // R2 R3: single line 7
    clear_log(); pulse_line(7); idle(5);
    chk("R8", "ack count line7", ack_q.size(), 1);
    if (ack_q.size() > 0) begin
      chk("R3", "inum line7", ack_q[0], 7);
      chk("R2", "vec line7", vec_q[0], 64'h10E0);
    end

    // R4: NMI, line 9 and line 5 together
    clear_log();
    nmi = 1; irq[5] = 1; irq[1] = 1; @(negedge clk);
    nmi = 0; irq[5] = 0; irq[1] = 0; idle(10);
    chk("R4", "ack count prio", ack_q.size(), 3);
    if (ack_q.size() == 3) begin
      chk("R4", "first", ack_q[0], 1);
      chk("R4", "second", ack_q[1], 5);
      chk("R4", "third", ack_q[2], 9);
      chk("R2", "nmi vec", vec_q[0], 64'h1020);
    end

    // R5 R6: line 6 masked, then enabled
    clear_log(); en[2] = 0; pulse_line(6); idle(20);
    chk("R5", "masked line6 acks", ack_q.size(), 0);
    en[2] = 1; idle(5);
    chk("R6", "line6 after enable", ack_q.size(), 1);
    if (ack_q.size() > 0) chk("R6", "line6 inum", ack_q[0], 6);

    // R5: global disable blocks line 10 but not NMI
    clear_log(); gie = 0; pulse_line(10); idle(5);
    nmi = 1; @(negedge clk); nmi = 0; idle(5);
    chk("R5", "acks with gie low", ack_q.size(), 1);
    if (ack_q.size() > 0) chk("R5", "nmi through gie low", ack_q[0], 1);
    gie = 1; idle(5);
    chk("R6", "line10 after gie", ack_q.size(), 2);

    // R6 R8: level held
    clear_log(); irq[8] = 1; idle(30); irq[8] = 0; idle(3);
    chk("R8", "held level acks", ack_q.size(), 1);

    // R7: not ready
    clear_log(); rdy = 0; pulse_line(4); idle(10);
    chk("R7", "no ack while not ready", ack_q.size(), 0);
    rdy = 1; idle(4);
    chk("R7", "ack once ready", ack_q.size(), 1);

    // R9: two edges while pending
    clear_log(); rdy = 0; pulse_line(8); idle(2); pulse_line(8); idle(3);
    rdy = 1; idle(6);
    chk("R9", "merged edges", ack_q.size(), 1);

    // R3 R2: reset source beats pending line 15
    clear_log(); rdy = 0; pulse_line(15); rst_src = 1; @(negedge clk); rst_src = 0;
    idle(2); rdy = 1; idle(8);
    chk("R4", "acks reset+15", ack_q.size(), 2);
    if (ack_q.size() == 2) begin
      chk("R3", "reset number", ack_q[0], 0);
      chk("R2", "reset vec", vec_q[0], 64'h1000);
      chk("R3", "line15 number", ack_q[1], 15);
    end

    // R2: relocated base
    clear_log(); base = 32'h8000_0200; pulse_line(15); idle(5);
    if (vec_q.size() > 0) chk("R2", "relocated vec", vec_q[0], 64'h8000_03E0);
    else chk("R2", "relocated ack count", vec_q.size(), 1);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule